// File: doc/BRIEF.md
# Cascadable Dual Compare-Match Timer

This block contains two 8-bit timers that count up. Each timer has its own compare register. On each enabled tick, a timer checks whether its count equals its compare value. If it does, the count returns to zero and a sticky interrupt request flag is set. If it does not, the count goes up by one. The same rule applies to both timers, so a timer repeats every (compare + 1) ticks.

Each timer picks its tick from three prescaler enable pulses or from a fourth source. For timer 0 the fourth source is an external input, which is synchronized inside the block and edge-detected. For timer 1 the fourth source chains the two timers into one 16-bit counter. In chained mode timer 1 holds the upper byte, and the pair matches against the two compare registers taken together. Only timer 0's run bits and tick govern the chained counter, and only the timer 0 request reports its matches.

Timer 0 has two run bits. The pause bit stops counting and keeps the current value. The start bit clears the counter while it is low, so setting it back to 1 restarts the count from zero. Timer 1 has only a start bit.

Top module: `cmt_dual_timer`

## Requirements
- R1: In 8-bit operation, a tick with count equal to compare loads 0 and sets the timer's request flag. Any other tick adds 1 to the count.
- R2: Timer 0 takes its tick from control bits [1:0]: 00 selects tick_a, 01 selects tick_b, 10 selects tick_c, 11 selects the synchronized external input. Pulses on the taps that are not selected are ignored.
- R3: Timer 1 takes its tick from control bits [5:4], where 00, 01 and 10 select tick_a, tick_b and tick_c in the same way.
- R4: With control bits [5:4] = 11, the counters form {cnt1,cnt0}. Timer 0 wrapping from FFh carries into timer 1. A tick on a 16-bit match with {cmp1,cmp0} clears both bytes and sets irq0, and irq1 is never set.
- R5: In chained mode, timer 1's start bit (control bit 6) and the prescaler taps have no effect on the upper byte.
- R6: Control bit 2 = 0 holds timer 0's count at its current value, ticks are ignored, and counting resumes from that value when the bit returns to 1.
- R7: Control bit 3 = 0 forces timer 0 to zero, and in chained mode it forces the upper byte to zero too. Control bit 6 = 0 does the same for timer 1 when the timers are not chained. Counting resumes from zero once the bit is 1 again.
- R8: In external mode, a rising edge on ext_in adds exactly one count, and that count appears on the third clock edge after the edge on ext_in.
- R9: A request flag stays set until its clear input is pulsed. A match in the same cycle as the clear keeps the flag set.
- R10: A compare write takes effect on the next tick. If the count is already above the new value, the count runs to FFh and wraps to 00h without a request.
- R11: Write addresses are 0 = control, 1 = cmp0, 2 = cmp1. After reset all registers, counts and request flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| tick_a | input | 1 | Prescaler tap A enable pulse |
| tick_b | input | 1 | Prescaler tap B enable pulse |
| tick_c | input | 1 | Prescaler tap C enable pulse |
| ext_in | input | 1 | External count input (asynchronous level) |
| irq0_clr | input | 1 | Clears the timer 0 request flag |
| irq1_clr | input | 1 | Clears the timer 1 request flag |
| irq0 | output | 1 | Timer 0 / chained match request |
| irq1 | output | 1 | Timer 1 match request |
| cnt0 | output | 8 | Timer 0 count |
| cnt1 | output | 8 | Timer 1 count (upper byte when chained) |

## Verification
The assertions assume that the tick inputs and the clear pulses are already in the system clock domain. They also assume that the control register only changes through the write port, so every property can treat the register as stable within a cycle. The bench drives every tap, clear and write on the falling clock edge and holds each for one full cycle. It raises ext_in and holds it for several cycles, which is longer than the synchronizer needs to see the edge.

// File: rtl/cmt_pkg.sv
// Shared definitions for the dual compare-match timer.
// Assumes a single 7-bit control register decoded at fixed bit positions.
package cmt_pkg;
    typedef enum logic [1:0] {
        SRC_TAP_A = 2'b00,
        SRC_TAP_B = 2'b01,
        SRC_TAP_C = 2'b10,
        SRC_ALT   = 2'b11
    } src_sel_e;

    localparam int CTL_W       = 7;
    localparam int T0_SEL_LSB  = 0;
    localparam int T0_RUN_BIT  = 2;
    localparam int T0_START_BIT= 3;
    localparam int T1_SEL_LSB  = 4;
    localparam int T1_START_BIT= 6;

    localparam logic [1:0] ADDR_CTL  = 2'd0;
    localparam logic [1:0] ADDR_CMP0 = 2'd1;
    localparam logic [1:0] ADDR_CMP1 = 2'd2;
endpackage

// File: rtl/cmt_edge_sync.sv
// Synchronizes an asynchronous level and emits a one-cycle pulse on its rise.
// Assumes STAGES >= 2; the pulse follows the input edge by STAGES+1 clock edges
// as seen at a counter fed by it.
module cmt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] chain_q;

    // Shift the input through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], din};
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/cmt_tick_sel.sv
// Four-way tick selector driven by a 2-bit source field.
// Assumes every tap is a single-cycle enable in the clock domain.
module cmt_tick_sel
    import cmt_pkg::*;
(
    input  src_sel_e   sel,
    input  logic [3:0] taps,
    output logic       tick
);
    // Route the chosen tap to the timer.
    always_comb begin
        unique case (sel)
            SRC_TAP_A: tick = taps[0];
            SRC_TAP_B: tick = taps[1];
            SRC_TAP_C: tick = taps[2];
            default:   tick = taps[3];
        endcase
    end
endmodule

// File: rtl/cmt_irq_flag.sv
// Sticky request flag: set has priority over clear.
// Assumes set and clr are single-cycle pulses in the clock domain.
module cmt_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the flag until a clear arrives without a coincident set.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/cmt_dual_timer.sv
// Two compare-match up-counters that can chain into one double-width counter.
// Assumes tick_a/b/c and the clear inputs are clock-domain single-cycle pulses;
// ext_in may be asynchronous. Control and compare registers are write-only.
module cmt_dual_timer
    import cmt_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             tick_a,
    input  logic             tick_b,
    input  logic             tick_c,
    input  logic             ext_in,
    input  logic             irq0_clr,
    input  logic             irq1_clr,
    output logic             irq0,
    output logic             irq1,
    output logic [CNT_W-1:0] cnt0,
    output logic [CNT_W-1:0] cnt1
);
    localparam int WIDE_W = 2 * CNT_W;

    logic [CTL_W-1:0] ctl_q;
    logic [CNT_W-1:0] cmp0_q, cmp1_q, cnt0_q, cnt1_q;
    logic             ext_rise, t0_tick, t1_tick;
    src_sel_e         t0_sel, t1_sel;
    logic             t0_start, t0_run, t1_start, chained;
    logic             t0_step, match0, match1, match_wide, t0_top;
    logic             hit0, hit1;

    // Capture register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            cmp0_q <= '0;
            cmp1_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTL:  ctl_q  <= wr_data[CTL_W-1:0];
                ADDR_CMP0: cmp0_q <= wr_data;
                ADDR_CMP1: cmp1_q <= wr_data;
                default:   ;
            endcase
        end
    end

    assign t0_sel   = src_sel_e'(ctl_q[T0_SEL_LSB +: 2]);
    assign t1_sel   = src_sel_e'(ctl_q[T1_SEL_LSB +: 2]);
    assign t0_start = ctl_q[T0_START_BIT];
    assign t0_run   = ctl_q[T0_RUN_BIT] & t0_start;
    assign t1_start = ctl_q[T1_START_BIT];
    assign chained  = (t1_sel == SRC_ALT);

    cmt_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_in),
        .rise  (ext_rise)
    );

    cmt_tick_sel u_t0_sel (
        .sel  (t0_sel),
        .taps ({ext_rise, tick_c, tick_b, tick_a}),
        .tick (t0_tick)
    );

    // The alternate source of timer 1 is handled by the chained path below.
    cmt_tick_sel u_t1_sel (
        .sel  (t1_sel),
        .taps ({1'b0, tick_c, tick_b, tick_a}),
        .tick (t1_tick)
    );

    assign t0_step    = t0_run & t0_tick;
    assign match0     = (cnt0_q == cmp0_q);
    assign match1     = (cnt1_q == cmp1_q);
    assign match_wide = ({cnt1_q, cnt0_q} == WIDE_W'({cmp1_q, cmp0_q}));
    assign t0_top     = (cnt0_q == {CNT_W{1'b1}});
    assign hit0       = t0_step & (chained ? match_wide : match0);
    assign hit1       = ~chained & t1_start & t1_tick & match1;

    // Lower byte / timer 0 counter.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt0_q <= '0;
        else if (!t0_start)  cnt0_q <= '0;
        else if (hit0)       cnt0_q <= '0;
        else if (t0_step)    cnt0_q <= cnt0_q + 1'b1;
    end

    // Upper byte in chained mode, independent timer 1 otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt1_q <= '0;
        end else if (chained) begin
            if (!t0_start)              cnt1_q <= '0;
            else if (hit0)              cnt1_q <= '0;
            else if (t0_step && t0_top) cnt1_q <= cnt1_q + 1'b1;
        end else begin
            if (!t1_start)              cnt1_q <= '0;
            else if (hit1)              cnt1_q <= '0;
            else if (t1_tick)           cnt1_q <= cnt1_q + 1'b1;
        end
    end

    cmt_irq_flag u_irq0 (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (hit0),
        .clr   (irq0_clr),
        .flag  (irq0)
    );

    cmt_irq_flag u_irq1 (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (hit1),
        .clr   (irq1_clr),
        .flag  (irq1)
    );

    assign cnt0 = cnt0_q;
    assign cnt1 = cnt1_q;
endmodule

// File: rtl/cmt_dual_timer_chk.sv
// Property checker for cmt_dual_timer, bound to every instance below.
// Assumes the control register changes only through the write port.
module cmt_dual_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [6:0]       ctl,
    input logic [CNT_W-1:0] cmp0,
    input logic             t0_tick,
    input logic             irq0_clr,
    input logic             irq1_clr,
    input logic             irq0,
    input logic             irq1,
    input logic [CNT_W-1:0] cnt0,
    input logic [CNT_W-1:0] cnt1
);
    logic chained, t0_go;
    assign chained = (ctl[5:4] == 2'b11);
    assign t0_go   = ctl[3] & ctl[2];

    AST_T0_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_go && t0_tick && !chained && cnt0 != cmp0) |=> cnt0 == CNT_W'($past(cnt0) + 1)); // R1
    AST_IRQ0_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq0) |-> cnt0 == '0); // R1
    AST_T0_IDLE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_go && !t0_tick) |=> $stable(cnt0)); // R2
    AST_CHAIN_NO_IRQ1: assert property (@(posedge clk) disable iff (!rst_n)
        (chained && !irq1) |=> !irq1); // R4
    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[3] && !ctl[2]) |=> $stable(cnt0)); // R6
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[3] |=> cnt0 == '0); // R7
    AST_CHAIN_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl[3] && chained) |=> cnt1 == '0); // R7
    AST_IRQ0_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq0 && !irq0_clr) |=> irq0); // R9
    AST_IRQ1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq1 && !irq1_clr) |=> irq1); // R9
endmodule

bind cmt_dual_timer cmt_dual_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl_q),
    .cmp0     (cmp0_q),
    .t0_tick  (t0_tick),
    .irq0_clr (irq0_clr),
    .irq1_clr (irq1_clr),
    .irq0     (irq0),
    .irq1     (irq1),
    .cnt0     (cnt0),
    .cnt1     (cnt1)
);

// File: tb/test_cmt_dual_timer.sv
module test_cmt_dual_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       tick_a = 1'b0, tick_b = 1'b0, tick_c = 1'b0, ext_in = 1'b0;
    logic       irq0_clr = 1'b0, irq1_clr = 1'b0;
    logic       irq0, irq1;
    logic [7:0] cnt0, cnt1;
    int         n_chk = 0, n_bad = 0;
    logic [7:0] held;

    cmt_dual_timer i_cmt_dual_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tick_a(tick_a), .tick_b(tick_b), .tick_c(tick_c), .ext_in(ext_in),
        .irq0_clr(irq0_clr), .irq1_clr(irq1_clr), .irq0(irq0), .irq1(irq1),
        .cnt0(cnt0), .cnt1(cnt1)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ctl(input logic [1:0] s0, input logic cn, input logic st0,
                                       input logic [1:0] s1, input logic st1);
        return {1'b0, st1, s1, st0, cn, s0};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // Clear both timers for one cycle, then apply the given control value.
    task automatic restart(input logic [7:0] c);
        wr(2'd0, c & 8'b1011_0111);
        wr(2'd0, c);
    endtask

    task automatic ticks(input int which, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_a = (which == 0); tick_b = (which == 1); tick_c = (which == 2);
        end
        @(negedge clk); tick_a = 1'b0; tick_b = 1'b0; tick_c = 1'b0;
    endtask

    task automatic clr_irqs();
        @(negedge clk); irq0_clr = 1'b1; irq1_clr = 1'b1;
        @(negedge clk); irq0_clr = 1'b0; irq1_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 cnt0", cnt0, 0); chk("R11 cnt1", cnt1, 0);
        chk("R11 irq0", irq0, 0); chk("R11 irq1", irq1, 0);

        // R1 every compare value on timer 0 via tap A
        for (int c = 0; c < 256; c++) begin
            wr(2'd1, 8'(c));
            restart(ctl(2'b00, 1, 1, 2'b00, 0));
            clr_irqs();
            chk("R9 irq0 cleared", irq0, 0);
            ticks(0, c);
            chk("R1 count to cmp", cnt0, c); chk("R1 no early irq", irq0, 0);
            ticks(0, 1);
            chk("R1 wrap to 0", cnt0, 0); chk("R1 irq0 set", irq0, 1);
        end

        // R3 timer 1 sweep over each tap
        for (int c = 0; c < 256; c += 17) begin
            for (int s = 0; s < 3; s++) begin
                wr(2'd2, 8'(c));
                restart(ctl(2'b00, 1, 0, 2'(s), 1));
                clr_irqs();
                ticks((s + 1) % 3, 3);
                chk("R3 other tap ignored", cnt1, 0);
                ticks(s, c);
                chk("R3 t1 count", cnt1, c); chk("R3 irq1 quiet", irq1, 0);
                ticks(s, 1);
                chk("R3 t1 wrap", cnt1, 0); chk("R3 irq1 set", irq1, 1);
            end
        end

        // R2 timer 0 tap selection
        wr(2'd1, 8'hFF);
        for (int s = 0; s < 3; s++) begin
            restart(ctl(2'(s), 1, 1, 2'b00, 0));
            ticks((s + 1) % 3, 4); ticks((s + 2) % 3, 4);
            chk("R2 unselected taps", cnt0, 0);
            ticks(s, s + 4);
            chk("R2 selected tap", cnt0, s + 4);
        end

        // R8 external source
        restart(ctl(2'b11, 1, 1, 2'b00, 0));
        ticks(0, 3);
        chk("R2 taps ignored in ext mode", cnt0, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); ext_in = 1'b1;
            @(negedge clk); @(negedge clk);
            chk("R8 not yet", cnt0, k);
            @(negedge clk);
            chk("R8 third edge", cnt0, k + 1);
            repeat (4) @(negedge clk);
            chk("R8 single count", cnt0, k + 1);
            ext_in = 1'b0;
            repeat (4) @(negedge clk);
        end

        // R6 pause keeps value
        restart(ctl(2'b00, 1, 1, 2'b00, 0));
        ticks(0, 5);
        wr(2'd0, ctl(2'b00, 0, 1, 2'b00, 0));
        ticks(0, 6);
        chk("R6 paused", cnt0, 5);
        wr(2'd0, ctl(2'b00, 1, 1, 2'b00, 0));
        ticks(0, 2);
        chk("R6 resumed", cnt0, 7);

        // R7 start bits clear
        wr(2'd2, 8'hFF);
        wr(2'd0, ctl(2'b00, 1, 1, 2'b00, 1));
        ticks(0, 9);
        wr(2'd0, ctl(2'b00, 1, 0, 2'b00, 0));
        @(negedge clk);
        chk("R7 t0 cleared", cnt0, 0); chk("R7 t1 cleared", cnt1, 0);
        wr(2'd0, ctl(2'b00, 1, 1, 2'b00, 1));
        ticks(0, 3);
        chk("R7 t0 from zero", cnt0, 3); chk("R7 t1 from zero", cnt1, 3);

        // R4/R5 chained 16-bit mode, compare 0x0102
        wr(2'd1, 8'h02); wr(2'd2, 8'h01);
        restart(ctl(2'b00, 1, 1, 2'b11, 0));
        clr_irqs();
        ticks(0, 255);
        chk("R4 low at top", cnt0, 255); chk("R4 high still 0", cnt1, 0);
        ticks(0, 1);
        chk("R4 carry low", cnt0, 0); chk("R4 carry high", cnt1, 1);
        ticks(2, 5); ticks(1, 5);
        chk("R5 taps ignored high", cnt1, 1); chk("R5 taps ignored low", cnt0, 0);
        ticks(0, 2);
        chk("R4 before match", cnt0, 2); chk("R4 no irq0 yet", irq0, 0);
        ticks(0, 1);
        chk("R4 match low", cnt0, 0); chk("R4 match high", cnt1, 0);
        chk("R4 irq0", irq0, 1); chk("R4 irq1 silent", irq1, 0);
        wr(2'd0, ctl(2'b00, 0, 1, 2'b11, 0));
        ticks(0, 4);
        chk("R5 t0 pause governs pair", cnt0, 0);

        // R9 match beats clear
        wr(2'd1, 8'd3);
        restart(ctl(2'b00, 1, 1, 2'b00, 0));
        ticks(0, 4);
        chk("R9 irq0 set", irq0, 1);
        ticks(0, 3);
        @(negedge clk); tick_a = 1'b1; irq0_clr = 1'b1;
        @(negedge clk); tick_a = 1'b0; irq0_clr = 1'b0;
        chk("R9 set wins", irq0, 1); chk("R9 matched", cnt0, 0);
        clr_irqs();
        chk("R9 cleared", irq0, 0);

        // R10 compare lowered below count
        wr(2'd1, 8'd20);
        restart(ctl(2'b00, 1, 1, 2'b00, 0));
        clr_irqs();
        ticks(0, 10);
        wr(2'd1, 8'd5);
        ticks(0, 245);
        held = cnt0;
        chk("R10 runs to top", held, 255); chk("R10 no irq", irq0, 0);
        ticks(0, 1);
        chk("R10 wraps", cnt0, 0); chk("R10 wrap silent", irq0, 0);
        ticks(0, 6);
        chk("R10 new cmp used", cnt0, 0); chk("R10 irq at new cmp", irq0, 1);

        // R11 unused address 3 leaves compare intact
        wr(2'd3, 8'd0);
        ticks(0, 5);
        chk("R11 addr3 ignored", cnt0, 5);

        summary();
    end
endmodule